// File: doc/BRIEF.md
# Serial-Loaded Control Register Bank

This block receives 24-bit control words over a three-wire serial link (serial clock, serial data, load strobe) and keeps them in a bank of six control registers. A word is shifted in most significant bit first. A rising edge on the load strobe copies the shifted word into the register whose index sits in the word's three lowest bits. The control bits stay part of the stored word.

All three serial wires are asynchronous to the system clock. They pass through a two-flop synchronizer, and their edges are detected in the system clock domain. The serial clock must therefore run well below the system clock, for example 20 MHz against 125 MHz.

Fields of registers 4 and 5 are combined with external pin levels to produce registered control outputs:
- a charge-pump current in microamps and a reference-source select,
- the direction and multiplication of the local-oscillator ports,
- a flag that marks routing of an external LO as valid,
- a gated modulator output enable,
- a multiplexed output that carries either the reference clock or the lock-detect level.

All six stored words are also driven out in full, for use by the rest of the chip.

Top module: `ctl_serial_bank`

## Requirements
- R1: A synchronous active-high reset clears all six registers to zero. After reset, `cp_ua` is 250, `cp_ext_ref` is 0, and `mux_out` follows `lock_det`.
- R2: On each rising edge of `sclk`, one bit of `sdata` is shifted in, most significant bit first. On a rising edge of `sle`, the last 24 bits are stored unchanged into register N, where N = word[2:0] is in the range 0 to 5. Register N appears on `reg_flat[24*N+23 : 24*N]`.
- R3: A load whose word[2:0] is 6 or 7 leaves all six registers unchanged.
- R4: A transfer happens only on the rising edge of `sle`. Bits shifted while `sle` stays high do not reach any register until the next rising edge of `sle`. Shifting continues throughout.
- R5: `cp_ua` equals 250 × (reg4[11:10] + 1), so codes 0, 1, 2 and 3 give 250, 500, 750 and 1000. `cp_ext_ref` equals reg4[18], where 1 selects the external resistor.
- R6: `mod_out_en` is 1 only when `mod_en_pin` is 1 and reg5[6] is 1.
- R7: `lo_is_out` is 1 when `lo_sel_pin` is 1 or reg5[3] is 1. When both are 0, the LO ports are inputs (`lo_is_out` = 0).
- R8: While `lo_is_out` is 1, reg5[5] = 1 sets `lo_1x` and reg5[5] = 0 sets `lo_2x`. Both are 0 while the ports are inputs.
- R9: `ext_lo_ok` is 1 only when the ports are inputs and reg5[4] is 1.
- R10: `mux_out` carries `ref_in` when reg5[8] is 1, and `lock_det` when reg5[8] is 0.
- R11: Each decoded output is registered. It reflects a pin change at the first rising clock edge after that change, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdata | input | 1 | Serial data, MSB first |
| sle | input | 1 | Load strobe; its rising edge transfers the word |
| lo_sel_pin | input | 1 | External LO direction pin |
| mod_en_pin | input | 1 | External modulator enable pin |
| ref_in | input | 1 | Reference signal for the multiplexed output |
| lock_det | input | 1 | Lock-detect level for the multiplexed output |
| reg_flat | output | 144 | Six stored words, register N at bits 24*N+23 to 24*N |
| cp_ua | output | 11 | Charge-pump current in microamps |
| cp_ext_ref | output | 1 | 1 selects the external current-setting resistor |
| lo_is_out | output | 1 | LO ports act as outputs |
| lo_1x | output | 1 | LO output at 1x frequency |
| lo_2x | output | 1 | LO output at 2x frequency |
| ext_lo_ok | output | 1 | External 2x LO routed to the modulator |
| mod_out_en | output | 1 | Modulator output enabled |
| mux_out | output | 1 | Reference or lock-detect output |

## Verification
The assertions take for granted that each level of `sclk` and `sle` lasts at least three system clock cycles, so that no synchronized edge is lost. They also assume that `sdata` is stable around each rising edge of `sclk`, and that external pins change only between clock edges. The stimulus holds every serial level for four cycles, changes `sdata` only while `sclk` is low, and drives every input on the falling edge of `clk`.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
  localparam int WORD_W    = 24;
  localparam int ADDR_W    = 3;
  localparam int NUM_REGS  = 6;
  localparam int CP_REG    = 4;
  localparam int LO_REG    = 5;
  localparam int CP_LSB    = 10;
  localparam int CP_EXT    = 18;
  localparam int LO_DRV    = 3;
  localparam int LO_EXT    = 4;
  localparam int LO_DIV    = 5;
  localparam int MOD_BIT   = 6;
  localparam int MUX_BIT   = 8;
  localparam int CP_STEP   = 250;
  localparam int CP_UA_W   = 11;
  localparam int SYNC_LEN  = 2;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign level[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_lvl,
  input  logic              sdata_lvl,
  input  logic              le_lvl,
  output logic              ld,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [WORD_W-1:0] ld_word
);
  logic [WORD_W-1:0] shift_q;
  logic              sclk_d, le_d;
  logic              sclk_rise, le_rise;

  assign sclk_rise = sclk_lvl & ~sclk_d;
  assign le_rise   = le_lvl & ~le_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      sclk_d  <= 1'b0;
      le_d    <= 1'b0;
      ld      <= 1'b0;
      ld_addr <= '0;
      ld_word <= '0;
    end else begin
      sclk_d <= sclk_lvl;
      le_d   <= le_lvl;
      if (sclk_rise) shift_q <= {shift_q[WORD_W-2:0], sdata_lvl};
      ld <= le_rise;
      if (le_rise) begin
        ld_word <= shift_q;
        ld_addr <= shift_q[ADDR_W-1:0];
      end
    end
  end

  // a held strobe yields exactly one load pulse
  assert_single_load_R4: assert property (@(posedge clk) disable iff (rst)
    ld |=> !ld);
  assert_load_on_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (le_d && $past(le_d)) |=> !ld);
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int WORD_W   = 24,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld,
  input  logic [ADDR_W-1:0]          ld_addr,
  input  logic [WORD_W-1:0]          ld_word,
  output logic [NUM_REGS*WORD_W-1:0] reg_flat
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)                                  word_q <= '0;
      else if (ld && ld_addr == ADDR_W'(k))     word_q <= ld_word;
    end
    assign reg_flat[k*WORD_W +: WORD_W] = word_q;

    assert_store_R2: assert property (@(posedge clk) disable iff (rst)
      (ld && ld_addr == ADDR_W'(k)) |=> (word_q == $past(ld_word)));
  end

  assert_unused_code_R3: assert property (@(posedge clk) disable iff (rst)
    (ld && int'(ld_addr) >= NUM_REGS) |=> $stable(reg_flat));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(reg_flat));
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode #(
  parameter int CP_UA_W = 11,
  parameter int CP_STEP = 250
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cp_code,
  input  logic               cp_ext_bit,
  input  logic               lo_drv_bit,
  input  logic               lo_ext_bit,
  input  logic               lo_div_bit,
  input  logic               mod_bit,
  input  logic               mux_bit,
  input  logic               lo_sel_pin,
  input  logic               mod_en_pin,
  input  logic               ref_in,
  input  logic               lock_det,
  output logic [CP_UA_W-1:0] cp_ua,
  output logic               cp_ext_ref,
  output logic               lo_is_out,
  output logic               lo_1x,
  output logic               lo_2x,
  output logic               ext_lo_ok,
  output logic               mod_out_en,
  output logic               mux_out
);
  logic dir_out;
  assign dir_out = lo_sel_pin | lo_drv_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_ua      <= CP_UA_W'(CP_STEP);
      cp_ext_ref <= 1'b0;
      lo_is_out  <= 1'b0;
      lo_1x      <= 1'b0;
      lo_2x      <= 1'b0;
      ext_lo_ok  <= 1'b0;
      mod_out_en <= 1'b0;
      mux_out    <= 1'b0;
    end else begin
      cp_ua      <= CP_UA_W'((int'(cp_code) + 1) * CP_STEP);
      cp_ext_ref <= cp_ext_bit;
      lo_is_out  <= dir_out;
      lo_1x      <= dir_out & lo_div_bit;
      lo_2x      <= dir_out & ~lo_div_bit;
      ext_lo_ok  <= ~dir_out & lo_ext_bit;
      mod_out_en <= mod_en_pin & mod_bit;
      mux_out    <= mux_bit ? ref_in : lock_det;
    end
  end

  assert_mod_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !mod_en_pin |=> !mod_out_en);
  assert_lo_pin_R7: assert property (@(posedge clk) disable iff (rst)
    lo_sel_pin |=> lo_is_out);
  assert_lo_mult_R8: assert property (@(posedge clk) disable iff (rst)
    lo_is_out |-> (lo_1x ^ lo_2x));
  assert_lo_in_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !lo_is_out |-> !(lo_1x || lo_2x));
  assert_ext_excl_R9: assert property (@(posedge clk) disable iff (rst)
    ext_lo_ok |-> !lo_is_out);
endmodule

// File: rtl/ctl_serial_bank.sv
module ctl_serial_bank
  import ctl_serial_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = ADDR_W,
  parameter int NR = NUM_REGS,
  parameter int UW = CP_UA_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sclk,
  input  logic           sdata,
  input  logic           sle,
  input  logic           lo_sel_pin,
  input  logic           mod_en_pin,
  input  logic           ref_in,
  input  logic           lock_det,
  output logic [NR*W-1:0] reg_flat,
  output logic [UW-1:0]  cp_ua,
  output logic           cp_ext_ref,
  output logic           lo_is_out,
  output logic           lo_1x,
  output logic           lo_2x,
  output logic           ext_lo_ok,
  output logic           mod_out_en,
  output logic           mux_out
);
  localparam int CP_BASE = CP_REG * W;
  localparam int LO_BASE = LO_REG * W;

  logic [2:0]    lvl;
  logic          ld;
  logic [AW-1:0] ld_addr;
  logic [W-1:0]  ld_word;

  serial_sync #(.N(3), .STAGES(SYNC_LEN)) i_sync (
    .clk(clk), .rst(rst), .async_in({sle, sdata, sclk}), .level(lvl));

  serial_shifter #(.WORD_W(W), .ADDR_W(AW)) i_shift (
    .clk(clk), .rst(rst), .sclk_lvl(lvl[0]), .sdata_lvl(lvl[1]),
    .le_lvl(lvl[2]), .ld(ld), .ld_addr(ld_addr), .ld_word(ld_word));

  reg_bank #(.WORD_W(W), .ADDR_W(AW), .NUM_REGS(NR)) i_bank (
    .clk(clk), .rst(rst), .ld(ld), .ld_addr(ld_addr), .ld_word(ld_word),
    .reg_flat(reg_flat));

  ctrl_decode #(.CP_UA_W(UW), .CP_STEP(CP_STEP)) i_dec (
    .clk(clk), .rst(rst),
    .cp_code(reg_flat[CP_BASE+CP_LSB +: 2]),
    .cp_ext_bit(reg_flat[CP_BASE+CP_EXT]),
    .lo_drv_bit(reg_flat[LO_BASE+LO_DRV]),
    .lo_ext_bit(reg_flat[LO_BASE+LO_EXT]),
    .lo_div_bit(reg_flat[LO_BASE+LO_DIV]),
    .mod_bit(reg_flat[LO_BASE+MOD_BIT]),
    .mux_bit(reg_flat[LO_BASE+MUX_BIT]),
    .lo_sel_pin(lo_sel_pin), .mod_en_pin(mod_en_pin),
    .ref_in(ref_in), .lock_det(lock_det),
    .cp_ua(cp_ua), .cp_ext_ref(cp_ext_ref), .lo_is_out(lo_is_out),
    .lo_1x(lo_1x), .lo_2x(lo_2x), .ext_lo_ok(ext_lo_ok),
    .mod_out_en(mod_out_en), .mux_out(mux_out));

  // R1: the cycle after reset shows cleared storage
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (reg_flat == '0));
endmodule

// File: tb/test_ctl_serial_bank.sv
module test_ctl_serial_bank;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 0, sdata = 0, sle = 0;
  logic lo_sel_pin = 0, mod_en_pin = 0, ref_in = 0, lock_det = 0;
  logic [143:0] reg_flat;
  logic [10:0]  cp_ua;
  logic cp_ext_ref, lo_is_out, lo_1x, lo_2x, ext_lo_ok, mod_out_en, mux_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [23:0] mregs [6];

  always #4 clk = ~clk;

  ctl_serial_bank i_ctl_serial_bank (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sle(sle),
    .lo_sel_pin(lo_sel_pin), .mod_en_pin(mod_en_pin), .ref_in(ref_in),
    .lock_det(lock_det), .reg_flat(reg_flat), .cp_ua(cp_ua),
    .cp_ext_ref(cp_ext_ref), .lo_is_out(lo_is_out), .lo_1x(lo_1x),
    .lo_2x(lo_2x), .ext_lo_ok(ext_lo_ok), .mod_out_en(mod_out_en),
    .mux_out(mux_out));

  // vector: {lock_det, ref_in, mod_en_pin, lo_sel_pin, word[23:0]}
  localparam logic [27:0] VEC [12] = '{
    {4'b0000, 24'hA5A5A0}, {4'b0001, 24'h123451}, {4'b0000, 24'hFEDCBA},
    {4'b1000, 24'h0F0F0B}, {4'b0000, 24'h000004}, {4'b1001, 24'h040C04},
    {4'b0000, 24'h000804}, {4'b0110, 24'h000145}, {4'b0000, 24'h00006D},
    {4'b1111, 24'hFFFFFE}, {4'b0100, 24'h00FFFF}, {4'b1010, 24'h000415}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      sclk = 0; sdata = w[i]; cyc(4);
      sclk = 1; cyc(4);
    end
    sclk = 0; cyc(4);
  endtask

  task automatic model_load(input logic [23:0] w);
    if (w[2:0] < 3'd6) mregs[w[2:0]] = w;
  endtask

  task automatic load_word(input logic [23:0] w);
    shift_word(w);
    sle = 1; cyc(8); sle = 0; cyc(4);
    model_load(w);
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < 6; k++)
      chk(reg_flat[k*24 +: 24] == mregs[k], req, 32'(reg_flat[k*24 +: 24]),
          32'(mregs[k]));
  endtask

  task automatic check_decode();
    logic [23:0] r4, r5;
    logic dir;
    r4 = mregs[4]; r5 = mregs[5];
    dir = lo_sel_pin | r5[3];
    chk(cp_ua == 11'((int'(r4[11:10]) + 1) * 250), "R5 cp_ua", 32'(cp_ua),
        32'((int'(r4[11:10]) + 1) * 250));
    chk(cp_ext_ref == r4[18], "R5 cp_ext_ref", 32'(cp_ext_ref), 32'(r4[18]));
    chk(mod_out_en == (mod_en_pin & r5[6]), "R6 mod_out_en", 32'(mod_out_en),
        32'(mod_en_pin & r5[6]));
    chk(lo_is_out == dir, "R7 lo_is_out", 32'(lo_is_out), 32'(dir));
    chk({lo_1x, lo_2x} == {dir & r5[5], dir & ~r5[5]}, "R8 lo mult",
        32'({lo_1x, lo_2x}), 32'({dir & r5[5], dir & ~r5[5]}));
    chk(ext_lo_ok == (~dir & r5[4]), "R9 ext_lo_ok", 32'(ext_lo_ok),
        32'(~dir & r5[4]));
    chk(mux_out == (r5[8] ? ref_in : lock_det), "R10 mux_out", 32'(mux_out),
        32'(r5[8] ? ref_in : lock_det));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) mregs[k] = '0;
    lock_det = 1;
    cyc(4); rst = 0; cyc(2);
    // R1 reset state
    check_regs("R1 reset regs");
    chk(cp_ua == 11'd250, "R1 cp_ua", 32'(cp_ua), 32'd250);
    chk(cp_ext_ref == 1'b0, "R1 cp_ext_ref", 32'(cp_ext_ref), 32'd0);
    chk(mux_out == 1'b1, "R1 mux lock_det", 32'(mux_out), 32'd1);

    // table walk: R2 storage, R3 unused codes, R5..R10 decode
    for (int v = 0; v < 12; v++) begin
      {lock_det, ref_in, mod_en_pin, lo_sel_pin} = VEC[v][27:24];
      load_word(VEC[v][23:0]);
      check_regs(VEC[v][2:1] == 2'b11 ? "R3 unused code" : "R2 store");
      check_decode();
    end

    // LO direction truth table: R7 R8 R9 over all pin/bit combinations
    for (int c = 0; c < 16; c++) begin
      lo_sel_pin = c[3];
      load_word({16'h0000, 1'b0, 1'b1, c[2], c[1], c[0], 3'd5});
      check_decode();
    end

    // R4: bits shifted while the strobe is held do not land
    load_word(24'h000005);
    sle = 1; cyc(8);
    shift_word(24'h0001E5);
    cyc(4);
    check_regs("R4 held strobe");
    check_decode();
    sle = 0; cyc(4); sle = 1; cyc(8); sle = 0; cyc(4);
    model_load(24'h0001E5);
    check_regs("R4 next edge");

    // R11: registered outputs react one edge after a pin change
    mod_en_pin = 0; cyc(2);
    mod_en_pin = 1; #1;
    chk(mod_out_en == 1'b0, "R11 before edge", 32'(mod_out_en), 32'd0);
    cyc(1);
    chk(mod_out_en == 1'b1, "R11 after edge", 32'(mod_out_en), 32'd1);
    ref_in = 0; cyc(1); ref_in = 1; cyc(1);
    chk(mux_out == 1'b1, "R10 R11 ref follow", 32'(mux_out), 32'd1);

    // R1: reset mid-run clears storage again
    rst = 1; cyc(2); rst = 0;
    for (int k = 0; k < 6; k++) mregs[k] = '0;
    cyc(1);
    check_regs("R1 second reset");
    check_decode();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule